// File: doc/BRIEF.md
# Page-Walk Interior Node Cache with Store Coherence

This block sits inside a hardware page walker and keeps a small set of upper-level directory entries so that later walks to nearby pages can skip levels already read. Each cached node is keyed by the physical location of the directory entry, in 8-byte units. It is not keyed by the virtual address that led to it. Two address spaces whose roots point into a shared subtree can therefore hit on the same node. The walker presents a lookup and gets a hit with the 64-bit entry one cycle later, or a miss. On a miss it reads the entry through the data-cache port and writes it back here with a fill.

Three inputs keep the contents safe without relying only on software. A root change clears everything. A single-address invalidate clears all nodes that belong to the current address-space ID. Every committed store's physical address is compared against all cached tags, and a match drops that node. A store that targets a fill's location in the same cycle cancels the fill.

Top module: `wnc_top`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is low, and every lookup misses.
- R2: A lookup taken with `lk_valid` high gives exactly one cycle with `rsp_valid` high, on the next cycle. `rsp_data` carries the entry on a hit and is zero on a miss. `rsp_valid` is low in any cycle that does not follow a lookup.
- R3: A lookup hits only when a valid entry has the same 8-byte-granular address (`lk_dw`), the same level (`lk_level`), and the ID `cur_asid` that was in force at fill time. The address alone identifies the node, so no root or virtual address takes part.
- R4: An entry filled under one ID never hits while `cur_asid` holds a different value. It hits again once that ID is current again.
- R5: A fill installs its address, level, data and the current ID. A new node goes into the slot named by a round-robin pointer that starts at slot 0 and advances by one, wrapping after `ENTRIES`. A fill that matches a valid entry in address, level and ID overwrites that entry's data and leaves the pointer where it is.
- R6: A store (`st_valid`) whose 8-byte address equals an entry's address invalidates that entry, whatever its ID and level. Other entries are untouched.
- R7: When a fill and a store to the same 8-byte address arrive in the same cycle, the fill is dropped and the node stays absent.
- R8: `flush_all` (root change) invalidates every entry. A fill in the same cycle is dropped.
- R9: `inv_one` invalidates every entry whose ID equals `cur_asid` and keeps entries of other IDs. A fill in the same cycle is dropped.
- R10: A lookup in the same cycle as a store, an `inv_one` or a `flush_all` sees the entries after that invalidation, so it never hits on an entry that the same cycle removes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Address-space ID currently in force |
| lk_valid | input | 1 | Lookup request |
| lk_dw | input | PA_W-3 | Lookup physical address, 8-byte units |
| lk_level | input | LVL_W | Tree level of the node looked up |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | DATA_W | Cached directory entry on a hit, zero on a miss |
| fill_valid | input | 1 | Install a node fetched after a miss |
| fill_dw | input | PA_W-3 | Fill physical address, 8-byte units |
| fill_level | input | LVL_W | Fill tree level |
| fill_data | input | DATA_W | Fetched directory entry |
| flush_all | input | 1 | Root change: clear all nodes |
| inv_one | input | 1 | Single-address invalidate: clear current-ID nodes |
| st_valid | input | 1 | Committed store present |
| st_dw | input | PA_W-3 | Store physical address, 8-byte units |

## Verification
A stuck valid bit or a missed store match shows up as a hit carrying stale data on the first lookup after the event. That lookup is answered one cycle later, so the error is visible at the ports within two cycles of the store, invalidate or flush. A round-robin pointer that goes wrong shows up as the wrong surviving node after an eviction: an older node hits where it should miss. An ID mix-up shows up as a hit under a foreign ID. The bench sweeps every slot, every level pairing and each kill source, both in the same cycle as a lookup and before it.

// File: rtl/wnc_pkg.sv
package wnc_pkg;
   // Directory entries are 8 bytes; tags drop this many address bits.
   localparam int unsigned WNC_GRAN_BITS = 3;

   function automatic bit wnc_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wnc_tag_cam.sv
module wnc_tag_cam #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TAG_W   = 37,
   parameter int unsigned ASID_W  = 8,
   parameter int unsigned LVL_W   = 2
) (
   input  logic [ENTRIES-1:0]             ent_valid,
   input  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag,
   input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
   input  logic [ENTRIES-1:0][LVL_W-1:0]  ent_lvl,
   input  logic [ASID_W-1:0]              cur_asid,
   input  logic [TAG_W-1:0]               lk_tag,
   input  logic [LVL_W-1:0]               lk_lvl,
   input  logic [TAG_W-1:0]               fl_tag,
   input  logic [LVL_W-1:0]               fl_lvl,
   input  logic [TAG_W-1:0]               st_tag,
   output logic [ENTRIES-1:0]             lk_match,
   output logic [ENTRIES-1:0]             fl_match,
   output logic [ENTRIES-1:0]             st_match,
   output logic [ENTRIES-1:0]             id_match
);
   // One comparator set per entry; the store compare is the coherence CAM.
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic id_eq;
      assign id_eq       = ent_valid[e] && (ent_asid[e] == cur_asid);
      assign id_match[e] = id_eq;
      assign lk_match[e] = id_eq && (ent_tag[e] == lk_tag) && (ent_lvl[e] == lk_lvl);
      assign fl_match[e] = id_eq && (ent_tag[e] == fl_tag) && (ent_lvl[e] == fl_lvl);
      assign st_match[e] = ent_valid[e] && (ent_tag[e] == st_tag);
   end
endmodule

// File: rtl/wnc_rr_victim.sv
module wnc_rr_victim #(
   parameter int unsigned ENTRIES = 8,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] slot
);
   if (wnc_pkg::wnc_is_pow2(ENTRIES)) begin : g_pow2
      always_ff @(posedge clk) begin
         if (!rst_n)   slot <= '0;
         else if (adv) slot <= slot + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   slot <= '0;
         else if (adv) slot <= (slot == IDX_W'(ENTRIES - 1)) ? '0 : slot + 1'b1;
      end
   end
endmodule

// File: rtl/wnc_store.sv
module wnc_store #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TAG_W   = 37,
   parameter int unsigned ASID_W  = 8,
   parameter int unsigned LVL_W   = 2,
   parameter int unsigned DATA_W  = 64,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ENTRIES-1:0]             kill,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [TAG_W-1:0]               wr_tag,
   input  logic [ASID_W-1:0]              wr_asid,
   input  logic [LVL_W-1:0]               wr_lvl,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [ENTRIES-1:0]             valid,
   output logic [ENTRIES-1:0][TAG_W-1:0]  tag,
   output logic [ENTRIES-1:0][ASID_W-1:0] asid,
   output logic [ENTRIES-1:0][LVL_W-1:0]  lvl,
   output logic [ENTRIES-1:0][DATA_W-1:0] data
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid[e] <= 1'b0;
            tag[e]   <= '0;
            asid[e]  <= '0;
            lvl[e]   <= '0;
            data[e]  <= '0;
         end else if (sel) begin
            valid[e] <= 1'b1;
            tag[e]   <= wr_tag;
            asid[e]  <= wr_asid;
            lvl[e]   <= wr_lvl;
            data[e]  <= wr_data;
         end else if (kill[e]) begin
            valid[e] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wnc_top.sv
module wnc_top #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned PA_W    = 40,
   parameter int unsigned ASID_W  = 8,
   parameter int unsigned LVL_W   = 2,
   parameter int unsigned DATA_W  = 64,
   localparam int unsigned TAG_W  = PA_W - wnc_pkg::WNC_GRAN_BITS,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              lk_valid,
   input  logic [TAG_W-1:0]  lk_dw,
   input  logic [LVL_W-1:0]  lk_level,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   input  logic              fill_valid,
   input  logic [TAG_W-1:0]  fill_dw,
   input  logic [LVL_W-1:0]  fill_level,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              flush_all,
   input  logic              inv_one,
   input  logic              st_valid,
   input  logic [TAG_W-1:0]  st_dw
);
   initial begin
      assert (ENTRIES >= 2) else $error("wnc_top: ENTRIES must be at least 2");
      assert (PA_W > wnc_pkg::WNC_GRAN_BITS + 1) else $error("wnc_top: PA_W too small");
      assert (ASID_W >= 1 && LVL_W >= 1 && DATA_W >= 1) else $error("wnc_top: zero width");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
   logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
   logic [ENTRIES-1:0][LVL_W-1:0]  ent_lvl;
   logic [ENTRIES-1:0][DATA_W-1:0] ent_data;

   logic [ENTRIES-1:0] lk_match, fl_match, st_match, id_match;
   logic [ENTRIES-1:0] kill, lk_live, fl_live;
   logic [IDX_W-1:0]   rr_slot, fl_idx, wr_idx;
   logic               fl_found, fill_ok, rr_adv, hit_now;
   logic [DATA_W-1:0]  hit_data;

   wnc_tag_cam #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ASID_W(ASID_W), .LVL_W(LVL_W)
   ) i_cam (
      .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_asid(ent_asid), .ent_lvl(ent_lvl),
      .cur_asid(cur_asid), .lk_tag(lk_dw), .lk_lvl(lk_level),
      .fl_tag(fill_dw), .fl_lvl(fill_level), .st_tag(st_dw),
      .lk_match(lk_match), .fl_match(fl_match), .st_match(st_match), .id_match(id_match)
   );

   // Invalidations of this cycle; lookups and refill matching see the survivors.
   always_comb begin
      if (flush_all) kill = '1;
      else           kill = (st_valid ? st_match : '0) | (inv_one ? id_match : '0);
   end
   assign lk_live = lk_match & ~kill;
   assign fl_live = fl_match & ~kill;

   always_comb begin
      hit_data = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (lk_live[e]) hit_data |= ent_data[e];
   end
   assign hit_now = |lk_live;

   always_comb begin
      fl_idx   = '0;
      fl_found = 1'b0;
      for (int e = ENTRIES - 1; e >= 0; e--)
         if (fl_live[e]) begin
            fl_idx   = IDX_W'(e);
            fl_found = 1'b1;
         end
   end

   // A store to the filled location, a flush or a current-ID invalidate cancels the fill.
   assign fill_ok = fill_valid && !flush_all && !inv_one && !(st_valid && (st_dw == fill_dw));
   assign rr_adv  = fill_ok && !fl_found;
   assign wr_idx  = fl_found ? fl_idx : rr_slot;

   wnc_rr_victim #(.ENTRIES(ENTRIES)) i_victim (
      .clk(clk), .rst_n(rst_n), .adv(rr_adv), .slot(rr_slot)
   );

   wnc_store #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ASID_W(ASID_W), .LVL_W(LVL_W), .DATA_W(DATA_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .kill(kill),
      .wr_en(fill_ok), .wr_idx(wr_idx), .wr_tag(fill_dw), .wr_asid(cur_asid),
      .wr_lvl(fill_level), .wr_data(fill_data),
      .valid(ent_valid), .tag(ent_tag), .asid(ent_asid), .lvl(ent_lvl), .data(ent_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && hit_now;
         rsp_data  <= (lk_valid && hit_now) ? hit_data : '0;
      end
   end
endmodule

// File: rtl/wnc_checker.sv
module wnc_checker #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TAG_W   = 37,
   parameter int unsigned DATA_W  = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [TAG_W-1:0]   lk_dw,
   input logic               st_valid,
   input logic [TAG_W-1:0]   st_dw,
   input logic               flush_all,
   input logic               inv_one,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic [DATA_W-1:0]  rsp_data,
   input logic [ENTRIES-1:0] ent_valid
);
   a_r2_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);
   a_r2_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_hit);
   a_r2_miss_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (ent_valid == '0));
   a_r5_one_install_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(ent_valid) <= $countones($past(ent_valid)) + 1));
   a_r10_store_blocks_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && st_valid && (st_dw == lk_dw)) |=> !rsp_hit);
   a_r10_flush_blocks_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && flush_all) |=> !rsp_hit);
   a_r9_inv_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      inv_one |=> ($countones(ent_valid) <= $countones($past(ent_valid))));
endmodule

bind wnc_top wnc_checker #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_wnc_checker (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_dw(lk_dw),
   .st_valid(st_valid), .st_dw(st_dw), .flush_all(flush_all), .inv_one(inv_one),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .ent_valid(ent_valid)
);

// File: tb/test_wnc_top.sv
module test_wnc_top;
   localparam int unsigned TAG_W = 37;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        cur_asid = '0;
   logic              lk_valid = 1'b0;
   logic [TAG_W-1:0]  lk_dw = '0;
   logic [1:0]        lk_level = '0;
   logic              rsp_valid, rsp_hit;
   logic [63:0]       rsp_data;
   logic              fill_valid = 1'b0;
   logic [TAG_W-1:0]  fill_dw = '0;
   logic [1:0]        fill_level = '0;
   logic [63:0]       fill_data = '0;
   logic              flush_all = 1'b0, inv_one = 1'b0, st_valid = 1'b0;
   logic [TAG_W-1:0]  st_dw = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wnc_top i_wnc_top (
      .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
      .lk_valid(lk_valid), .lk_dw(lk_dw), .lk_level(lk_level),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .fill_valid(fill_valid), .fill_dw(fill_dw), .fill_level(fill_level), .fill_data(fill_data),
      .flush_all(flush_all), .inv_one(inv_one), .st_valid(st_valid), .st_dw(st_dw)
   );

   function automatic logic [TAG_W-1:0] pa_of(input int i);
      return TAG_W'(37'h0_4000_0000 + i * 13);
   endfunction
   function automatic logic [63:0] dat_of(input int i);
      return 64'hC0DE_0000_0000_0000 | (64'(i) * 64'h0001_0101);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_rsp(input bit exp_hit, input logic [63:0] exp_data, input string req);
      logic [63:0] ed;
      ed = exp_hit ? exp_data : 64'h0;
      chk(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'h1);
      chk(rsp_hit == exp_hit, req, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
      chk(rsp_data == ed, req, "rsp_data", rsp_data, ed);
   endtask

   task automatic lookup(input logic [TAG_W-1:0] pa, input logic [1:0] lvl,
                         input bit exp_hit, input logic [63:0] exp_data, input string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_dw = pa; lk_level = lvl;
      @(negedge clk);
      lk_valid = 1'b0;
      check_rsp(exp_hit, exp_data, req);
   endtask

   task automatic fill(input logic [TAG_W-1:0] pa, input logic [1:0] lvl, input logic [63:0] d);
      @(negedge clk);
      fill_valid = 1'b1; fill_dw = pa; fill_level = lvl; fill_data = d;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic store(input logic [TAG_W-1:0] pa);
      @(negedge clk);
      st_valid = 1'b1; st_dw = pa;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty after reset
      chk(rsp_valid == 1'b0, "R1", "rsp_valid idle", 64'(rsp_valid), 64'h0);
      lookup(pa_of(0), 2'd2, 1'b0, 64'h0, "R1");
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2", "rsp_valid drops", 64'(rsp_valid), 64'h0);

      // R5/R3: fill all slots, hit each
      cur_asid = 8'd5;
      for (int i = 0; i < 8; i++) fill(pa_of(i), 2'd2, dat_of(i));
      for (int i = 0; i < 8; i++) lookup(pa_of(i), 2'd2, 1'b1, dat_of(i), "R3");
      lookup(pa_of(3), 2'd1, 1'b0, 64'h0, "R3");
      lookup(pa_of(3), 2'd2, 1'b1, dat_of(3), "R3");   // same node, reached from any root

      // R5: refill in place keeps pointer; next new node evicts slot 0
      fill(pa_of(2), 2'd2, dat_of(102));
      lookup(pa_of(2), 2'd2, 1'b1, dat_of(102), "R5");
      fill(pa_of(8), 2'd2, dat_of(8));
      lookup(pa_of(0), 2'd2, 1'b0, 64'h0, "R5");
      lookup(pa_of(1), 2'd2, 1'b1, dat_of(1), "R5");
      lookup(pa_of(8), 2'd2, 1'b1, dat_of(8), "R5");
      fill(pa_of(9), 2'd2, dat_of(9));
      lookup(pa_of(1), 2'd2, 1'b0, 64'h0, "R5");
      lookup(pa_of(9), 2'd2, 1'b1, dat_of(9), "R5");

      // R4: foreign ID never hits; own-ID fill evicts slot 2
      cur_asid = 8'd6;
      lookup(pa_of(3), 2'd2, 1'b0, 64'h0, "R4");
      fill(pa_of(3), 2'd2, dat_of(203));
      lookup(pa_of(3), 2'd2, 1'b1, dat_of(203), "R4");
      cur_asid = 8'd5;
      lookup(pa_of(3), 2'd2, 1'b1, dat_of(3), "R4");
      lookup(pa_of(2), 2'd2, 1'b0, 64'h0, "R5");

      // R6: store snoop
      store(pa_of(4));
      lookup(pa_of(4), 2'd2, 1'b0, 64'h0, "R6");
      lookup(pa_of(5), 2'd2, 1'b1, dat_of(5), "R6");
      store(pa_of(3));
      lookup(pa_of(3), 2'd2, 1'b0, 64'h0, "R6");
      cur_asid = 8'd6;
      lookup(pa_of(3), 2'd2, 1'b0, 64'h0, "R6");
      cur_asid = 8'd5;

      // R7: store and fill to the same location
      @(negedge clk);
      fill_valid = 1'b1; fill_dw = pa_of(10); fill_level = 2'd2; fill_data = dat_of(10);
      st_valid = 1'b1; st_dw = pa_of(10);
      @(negedge clk);
      fill_valid = 1'b0; st_valid = 1'b0;
      lookup(pa_of(10), 2'd2, 1'b0, 64'h0, "R7");

      // R10: lookup with same-cycle store
      @(negedge clk);
      lk_valid = 1'b1; lk_dw = pa_of(5); lk_level = 2'd2; st_valid = 1'b1; st_dw = pa_of(5);
      @(negedge clk);
      lk_valid = 1'b0; st_valid = 1'b0;
      check_rsp(1'b0, 64'h0, "R10");
      lookup(pa_of(5), 2'd2, 1'b0, 64'h0, "R6");
      @(negedge clk);
      lk_valid = 1'b1; lk_dw = pa_of(6); lk_level = 2'd2; st_valid = 1'b1; st_dw = pa_of(7);
      @(negedge clk);
      lk_valid = 1'b0; st_valid = 1'b0;
      check_rsp(1'b1, dat_of(6), "R10");

      // R9: single-address invalidate by current ID
      cur_asid = 8'd6;
      fill(pa_of(11), 2'd2, dat_of(11));
      cur_asid = 8'd5;
      @(negedge clk);
      inv_one = 1'b1; lk_valid = 1'b1; lk_dw = pa_of(8); lk_level = 2'd2;
      @(negedge clk);
      inv_one = 1'b0; lk_valid = 1'b0;
      check_rsp(1'b0, 64'h0, "R10");
      lookup(pa_of(8), 2'd2, 1'b0, 64'h0, "R9");
      lookup(pa_of(9), 2'd2, 1'b0, 64'h0, "R9");
      cur_asid = 8'd6;
      lookup(pa_of(11), 2'd2, 1'b1, dat_of(11), "R9");
      @(negedge clk);
      inv_one = 1'b1; fill_valid = 1'b1; fill_dw = pa_of(12); fill_level = 2'd2; fill_data = dat_of(12);
      @(negedge clk);
      inv_one = 1'b0; fill_valid = 1'b0;
      lookup(pa_of(12), 2'd2, 1'b0, 64'h0, "R9");
      lookup(pa_of(11), 2'd2, 1'b0, 64'h0, "R9");

      // R8: flush with same-cycle lookup and fill
      cur_asid = 8'd5;
      fill(pa_of(13), 2'd1, dat_of(13));
      fill(pa_of(14), 2'd1, dat_of(14));
      lookup(pa_of(13), 2'd1, 1'b1, dat_of(13), "R8");
      @(negedge clk);
      flush_all = 1'b1; lk_valid = 1'b1; lk_dw = pa_of(14); lk_level = 2'd1;
      fill_valid = 1'b1; fill_dw = pa_of(15); fill_level = 2'd1; fill_data = dat_of(15);
      @(negedge clk);
      flush_all = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
      check_rsp(1'b0, 64'h0, "R10");
      lookup(pa_of(13), 2'd1, 1'b0, 64'h0, "R8");
      lookup(pa_of(14), 2'd1, 1'b0, 64'h0, "R8");
      lookup(pa_of(15), 2'd1, 1'b0, 64'h0, "R8");

      // R3 sweep: every slot against every level
      for (int i = 0; i < 8; i++) fill(pa_of(20 + i), 2'(i % 3 + 1), dat_of(20 + i));
      for (int i = 0; i < 8; i++)
         for (int l = 0; l < 4; l++)
            lookup(pa_of(20 + i), 2'(l), (l == i % 3 + 1), dat_of(20 + i), "R3");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule